// File: doc/BRIEF.md
# I3C Bus Command-Framing Transaction Router

This block sits on the controller side of an I3C bus. It sequences transactions toward a group of target engines. The host issues a stream of bus operations: START or repeated START carrying a 7-bit address and a direction, STOP, single-byte writes and single-byte reads. The router follows the command framing that these operations imply. It works out whether the current frame was opened with the broadcast address, whether a common command code has been latched, and whether a dynamic address assignment round is under way.

From that framing it keeps a match vector of the targets that take part in the current frame. It forwards every operation to those targets as a registered event and merges their replies into one ACK/NACK result per operation. For reads it returns the data byte of the lowest-index participant. An assignment round survives repeated STARTs and ends only at a STOP. That STOP is sent to every target, because targets drop out of the round one by one as they receive addresses. Replies to broadcast commands are never reported as NACK.

The framing is a six-state machine:
- `FR_IDLE`: no frame is open.
- `FR_PRIV`: a private transfer to a non-broadcast address, with no command active.
- `FR_BCAST`: a broadcast START has been seen and the command code is awaited.
- `FR_CCC`: a broadcast command is active.
- `FR_DIRCCC`: a command is still active and a non-broadcast repeated START has addressed individual targets.
- `FR_DAA`: an address assignment round is under way.

Transitions:
- Broadcast START: from `FR_DAA` back to `FR_DAA`; from every other state to `FR_BCAST`.
- Non-broadcast START: from `FR_CCC` or `FR_DIRCCC` to `FR_DIRCCC`; from `FR_DAA` to `FR_DAA`; from the other states to `FR_PRIV`.
- WRITE in `FR_BCAST`: to `FR_DAA` if the byte equals the assignment code, otherwise to `FR_CCC`.
- STOP: from any state to `FR_IDLE`.
- Any other operation leaves the state unchanged.

Top module: `i3c_ccc_router`

## Requirements
- R1: After reset, `rsp_valid`, `tgt_evt_valid` and `busy` are low and `tgt_sel` is all zeros.
- R2: Each accepted operation (`cmd_valid` high) produces exactly one target event in the next cycle and one response in the cycle after that.
  - Operation codes on `cmd_op`: START=0, STOP=1, WRITE=2, READ=3.
  - Event kinds on `tgt_evt_kind`: START-write=0, START-read=1, WRITE=2, READ=3, STOP=4.
- R3: A START to address 0x7E outside an assignment round selects every target and cancels any active command. The first byte written after it is latched as the command code: that write's event shows `tgt_evt_cmd`=1, and `tgt_evt_code` shows the byte.
- R4: Every START replaces the match vector. A non-broadcast START selects the targets whose `tgt_addr` field equals the address. A START that selects no target is answered with `rsp_nack`=1; otherwise it is answered with `rsp_nack`=0.
- R5: A latched code equal to 0x07 opens an assignment round. Inside the round, a START to 0x7E selects only the targets with `tgt_has_da`=0, and a START to any other address selects none. The round persists across repeated STARTs.
- R6: While a command is active, a WRITE or READ whose code has bit 7 clear is answered with ACK whatever the targets reply. With bit 7 set, and outside commands, a WRITE is answered with the OR of the selected targets' `tgt_nack`.
- R7: A STOP that closes an assignment round is sent with `tgt_sel` all ones. Any other STOP is sent to the current match vector only. A STOP clears the match vector and all framing, so a following write has `tgt_evt_cmd`=0.
- R8: A READ returns the `tgt_rdata` byte of the lowest-index selected target, with that target's `tgt_nack` (masked as in R6). With no target selected it returns 0xFF with ACK.
- R9: `busy` is high exactly while the match vector is non-zero.
- R10: A non-broadcast repeated START during an active command keeps the command and its code active (`tgt_evt_cmd`=1 on later writes). A repeated START to 0x7E outside a round cancels the command, so the next written byte becomes a new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Operation present this cycle |
| cmd_op | input | 2 | Operation code (START=0, STOP=1, WRITE=2, READ=3) |
| cmd_addr | input | 7 | Address carried by a START |
| cmd_rnw | input | 1 | START direction, 1 = read |
| cmd_wdata | input | 8 | Byte carried by a WRITE |
| rsp_valid | output | 1 | Response strobe |
| rsp_nack | output | 1 | Merged NACK result |
| rsp_rdata | output | 8 | Read byte, 0xFF when not a read |
| busy | output | 1 | Match vector non-zero |
| tgt_addr | input | N_TGT*7 | Current address of each target |
| tgt_has_da | input | N_TGT | Target already holds a dynamic address |
| tgt_nack | input | N_TGT | Per-target NACK reply to the current event |
| tgt_rdata | input | N_TGT*8 | Per-target read byte for the current event |
| tgt_evt_valid | output | 1 | Event strobe toward targets |
| tgt_evt_kind | output | 3 | Event kind |
| tgt_evt_data | output | 8 | Address (START) or byte (WRITE) |
| tgt_evt_cmd | output | 1 | Event belongs to an active command |
| tgt_evt_code | output | 8 | Latched command code |
| tgt_sel | output | N_TGT | Targets addressed by the event |

## Verification
The bench builds the router with its defaults: four targets at addresses 0x10 to 0x13, a broadcast address of 0x7E and an assignment code of 0x07. Four targets are enough to make a partially populated assignment round, such as two targets already holding addresses, and lowest-index read selection among several participants both observable. A spare address, 0x33, gives the no-match NACK path, and the code bytes 0x01, 0x85 and 0x07 reach the masked, unmasked and assignment branches. Random sequences drawn from that small address and code pool interleave repeated STARTs, reads and STOPs, so every framing transition is reached many times.

// File: rtl/i3r_pkg.sv
package i3r_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        EV_START_WR = 3'd0,
        EV_START_RD = 3'd1,
        EV_WRITE    = 3'd2,
        EV_READ     = 3'd3,
        EV_STOP     = 3'd4
    } ev_e;

    typedef enum logic [2:0] {
        FR_IDLE   = 3'd0,
        FR_PRIV   = 3'd1,
        FR_BCAST  = 3'd2,
        FR_CCC    = 3'd3,
        FR_DIRCCC = 3'd4,
        FR_DAA    = 3'd5
    } frame_e;

endpackage

// File: rtl/i3r_frame_fsm.sv
module i3r_frame_fsm
    import i3r_pkg::*;
#(
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   DAA_CODE = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  op_e           op,
    input  logic          is_bc,
    input  logic [DW-1:0] wdata,
    output frame_e        frame_q,
    output logic [DW-1:0] code_q,
    output logic          in_cmd,
    output logic          in_daa
);

    frame_e        frame_d;
    logic [DW-1:0] code_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= FR_IDLE;
            code_q  <= '0;
        end else begin
            frame_q <= frame_d;
            code_q  <= code_d;
        end
    end

    // next-state logic
    always_comb begin
        frame_d = frame_q;
        code_d  = code_q;
        if (cmd_valid) begin
            unique case (op)
                OP_START: begin
                    unique case (frame_q)
                        FR_DAA:           frame_d = FR_DAA;
                        FR_CCC, FR_DIRCCC: frame_d = is_bc ? FR_BCAST : FR_DIRCCC;
                        default:          frame_d = is_bc ? FR_BCAST : FR_PRIV;
                    endcase
                end
                OP_STOP: begin
                    frame_d = FR_IDLE;
                    code_d  = '0;
                end
                OP_WRITE: begin
                    if (frame_q == FR_BCAST) begin
                        code_d  = wdata;
                        frame_d = (wdata == DAA_CODE) ? FR_DAA : FR_CCC;
                    end
                end
                OP_READ: begin
                end
            endcase
        end
    end

    // state-derived outputs
    always_comb begin
        in_cmd = 1'b0;
        in_daa = 1'b0;
        unique case (frame_q)
            FR_CCC, FR_DIRCCC: in_cmd = 1'b1;
            FR_DAA: begin
                in_cmd = 1'b1;
                in_daa = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/i3r_matcher.sv
module i3r_matcher #(
    parameter int N_TGT = 4,
    parameter int AW    = 7
) (
    input  logic [AW-1:0]       addr,
    input  logic                is_bc,
    input  logic                in_daa,
    input  logic [N_TGT*AW-1:0] tgt_addr,
    input  logic [N_TGT-1:0]    tgt_has_da,
    output logic [N_TGT-1:0]    hit
);

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        // inside a round only address-less targets answer, and only to broadcast
        assign hit[i] = in_daa ? (is_bc && !tgt_has_da[i])
                               : (is_bc || (tgt_addr[i*AW +: AW] == addr));
    end

endmodule

// File: rtl/i3r_first_pick.sv
module i3r_first_pick #(
    parameter int N_TGT = 4,
    parameter int DW    = 8
) (
    input  logic [N_TGT-1:0]    sel,
    input  logic [N_TGT*DW-1:0] rdata,
    input  logic [N_TGT-1:0]    nack,
    output logic                any,
    output logic [DW-1:0]       first_data,
    output logic                first_nack
);

    always_comb begin
        any        = |sel;
        first_data = '1;
        first_nack = 1'b0;
        // scan from the top so the lowest set index wins
        for (int i = N_TGT - 1; i >= 0; i--) begin
            if (sel[i]) begin
                first_data = rdata[i*DW +: DW];
                first_nack = nack[i];
            end
        end
    end

endmodule

// File: rtl/i3c_ccc_router.sv
module i3c_ccc_router
    import i3r_pkg::*;
#(
    parameter int             N_TGT      = 4,
    parameter int             AW         = 7,
    parameter int             DW         = 8,
    parameter logic [AW-1:0]  BCAST_ADDR = 7'h7E,
    parameter logic [DW-1:0]  DAA_CODE   = 8'h07
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    input  logic                cmd_rnw,
    input  logic [DW-1:0]       cmd_wdata,
    output logic                rsp_valid,
    output logic                rsp_nack,
    output logic [DW-1:0]       rsp_rdata,
    output logic                busy,
    input  logic [N_TGT*AW-1:0] tgt_addr,
    input  logic [N_TGT-1:0]    tgt_has_da,
    input  logic [N_TGT-1:0]    tgt_nack,
    input  logic [N_TGT*DW-1:0] tgt_rdata,
    output logic                tgt_evt_valid,
    output logic [2:0]          tgt_evt_kind,
    output logic [DW-1:0]       tgt_evt_data,
    output logic                tgt_evt_cmd,
    output logic [DW-1:0]       tgt_evt_code,
    output logic [N_TGT-1:0]    tgt_sel
);

    localparam int DIRECT_BIT = DW - 1;
    localparam int ADDR_PAD   = DW - AW;

    op_e              op;
    logic             is_bc;
    frame_e           frame_q;
    logic [DW-1:0]    code_q;
    logic             in_cmd;
    logic             in_daa;
    logic [N_TGT-1:0] hit;
    logic [N_TGT-1:0] match_q;
    logic [N_TGT-1:0] sel_q;
    ev_e              kind_q;
    logic             evt_valid_q;
    logic [DW-1:0]    evt_data_q;
    logic             pick_any;
    logic [DW-1:0]    pick_data;
    logic             pick_nack;
    logic             nack_mask;
    logic             wr_nack_raw;

    assign op    = op_e'(cmd_op);
    assign is_bc = (cmd_addr == BCAST_ADDR);

    i3r_frame_fsm #(
        .DW       (DW),
        .DAA_CODE (DAA_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .is_bc     (is_bc),
        .wdata     (cmd_wdata),
        .frame_q   (frame_q),
        .code_q    (code_q),
        .in_cmd    (in_cmd),
        .in_daa    (in_daa)
    );

    i3r_matcher #(
        .N_TGT (N_TGT),
        .AW    (AW)
    ) u_match (
        .addr       (cmd_addr),
        .is_bc      (is_bc),
        .in_daa     (in_daa),
        .tgt_addr   (tgt_addr),
        .tgt_has_da (tgt_has_da),
        .hit        (hit)
    );

    i3r_first_pick #(
        .N_TGT (N_TGT),
        .DW    (DW)
    ) u_pick (
        .sel        (sel_q),
        .rdata      (tgt_rdata),
        .nack       (tgt_nack),
        .any        (pick_any),
        .first_data (pick_data),
        .first_nack (pick_nack)
    );

    // event stage: one registered event per accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid_q <= 1'b0;
            kind_q      <= EV_STOP;
            sel_q       <= '0;
            match_q     <= '0;
            evt_data_q  <= '0;
        end else begin
            evt_valid_q <= cmd_valid;
            if (cmd_valid) begin
                unique case (op)
                    OP_START: begin
                        kind_q     <= cmd_rnw ? EV_START_RD : EV_START_WR;
                        sel_q      <= hit;
                        match_q    <= hit;
                        evt_data_q <= {{ADDR_PAD{1'b0}}, cmd_addr};
                    end
                    OP_STOP: begin
                        kind_q     <= EV_STOP;
                        sel_q      <= in_daa ? {N_TGT{1'b1}} : match_q;
                        match_q    <= '0;
                        evt_data_q <= '0;
                    end
                    OP_WRITE: begin
                        kind_q     <= EV_WRITE;
                        sel_q      <= match_q;
                        evt_data_q <= cmd_wdata;
                    end
                    OP_READ: begin
                        kind_q     <= EV_READ;
                        sel_q      <= match_q;
                        evt_data_q <= '0;
                    end
                endcase
            end
        end
    end

    // broadcast commands never report NACK
    assign nack_mask   = in_cmd && !code_q[DIRECT_BIT];
    assign wr_nack_raw = |(sel_q & tgt_nack);

    // response stage: merge target replies one cycle after the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_nack  <= 1'b0;
            rsp_rdata <= '1;
        end else begin
            rsp_valid <= evt_valid_q;
            if (evt_valid_q) begin
                unique case (kind_q)
                    EV_START_WR, EV_START_RD: begin
                        rsp_nack  <= ~|sel_q;
                        rsp_rdata <= '1;
                    end
                    EV_WRITE: begin
                        rsp_nack  <= wr_nack_raw && !nack_mask;
                        rsp_rdata <= '1;
                    end
                    EV_READ: begin
                        rsp_nack  <= pick_any && pick_nack && !nack_mask;
                        rsp_rdata <= pick_data;
                    end
                    default: begin
                        rsp_nack  <= 1'b0;
                        rsp_rdata <= '1;
                    end
                endcase
            end
        end
    end

    assign busy          = |match_q;
    assign tgt_evt_valid = evt_valid_q;
    assign tgt_evt_kind  = kind_q;
    assign tgt_evt_data  = evt_data_q;
    assign tgt_evt_cmd   = in_cmd;
    assign tgt_evt_code  = code_q;
    assign tgt_sel       = sel_q;

endmodule

// File: rtl/i3r_checker.sv
module i3r_checker
    import i3r_pkg::*;
#(
    parameter int N_TGT = 4,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input frame_e           frame_q,
    input logic             tgt_evt_valid,
    input logic [2:0]       tgt_evt_kind,
    input logic             tgt_evt_cmd,
    input logic [DW-1:0]    tgt_evt_code,
    input logic [N_TGT-1:0] tgt_sel,
    input logic             rsp_valid,
    input logic             rsp_nack,
    input logic [DW-1:0]    rsp_rdata,
    input logic             busy
);

    a_r2_event_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> tgt_evt_valid);

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_evt_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_evt_valid |=> !rsp_valid);

    a_r4_empty_start_nacks: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_evt_valid && (tgt_evt_kind == EV_START_WR || tgt_evt_kind == EV_START_RD)
        && (tgt_sel == '0) |=> rsp_nack);

    a_r5_round_survives_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_START && frame_q == FR_DAA |=> frame_q == FR_DAA);

    a_r6_broadcast_write_acks: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_evt_valid && tgt_evt_kind == EV_WRITE && tgt_evt_cmd && !tgt_evt_code[DW-1]
        |=> !rsp_nack);

    a_r7_round_stop_all: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_STOP && frame_q == FR_DAA |=> (&tgt_sel));

    a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_STOP |=> !busy);

    a_r8_empty_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_evt_valid && tgt_evt_kind == EV_READ && tgt_sel == '0
        |=> (rsp_rdata == '1) && !rsp_nack);

endmodule

bind i3c_ccc_router i3r_checker #(.N_TGT(N_TGT), .DW(DW)) u_i3r_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .frame_q       (frame_q),
    .tgt_evt_valid (tgt_evt_valid),
    .tgt_evt_kind  (tgt_evt_kind),
    .tgt_evt_cmd   (tgt_evt_cmd),
    .tgt_evt_code  (tgt_evt_code),
    .tgt_sel       (tgt_sel),
    .rsp_valid     (rsp_valid),
    .rsp_nack      (rsp_nack),
    .rsp_rdata     (rsp_rdata),
    .busy          (busy)
);

// File: tb/i3c_ccc_router_bench.sv
module i3c_ccc_router_bench;

    localparam int N  = 4;
    localparam int AW = 7;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = 2'd0;
    logic [AW-1:0]   cmd_addr = '0;
    logic            cmd_rnw = 1'b0;
    logic [DW-1:0]   cmd_wdata = '0;
    logic            rsp_valid, rsp_nack, busy;
    logic [DW-1:0]   rsp_rdata;
    logic [N*AW-1:0] t_addr;
    logic [N-1:0]    t_hasda = '0;
    logic [N-1:0]    t_nack = '0;
    logic [N*DW-1:0] t_rdata;
    logic            evt_valid, evt_cmd;
    logic [2:0]      evt_kind;
    logic [DW-1:0]   evt_data, evt_code;
    logic [N-1:0]    sel;

    int total = 0;
    int bad = 0;

    // bench-side framing model
    bit           m_bc, m_ccc, m_daa;
    logic [7:0]   m_code;
    logic [N-1:0] m_match;

    always #5 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_tgt
        assign t_addr[i*AW +: AW]  = 7'h10 + 7'(i);
        assign t_rdata[i*DW +: DW] = 8'hA0 + 8'(i);
    end

    i3c_ccc_router u_i3c_ccc_router (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_addr (cmd_addr), .cmd_rnw (cmd_rnw), .cmd_wdata (cmd_wdata),
        .rsp_valid (rsp_valid), .rsp_nack (rsp_nack), .rsp_rdata (rsp_rdata),
        .busy (busy), .tgt_addr (t_addr), .tgt_has_da (t_hasda),
        .tgt_nack (t_nack), .tgt_rdata (t_rdata), .tgt_evt_valid (evt_valid),
        .tgt_evt_kind (evt_kind), .tgt_evt_data (evt_data), .tgt_evt_cmd (evt_cmd),
        .tgt_evt_code (evt_code), .tgt_sel (sel)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_hit(input logic [6:0] a, input bit daa,
                                             input logic [N-1:0] hasda);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) begin
            if (daa) h[i] = (a == 7'h7E) && !hasda[i];
            else     h[i] = (a == 7'h7E) || (a == 7'h10 + 7'(i));
        end
        return h;
    endfunction

    // op: 0 START, 1 STOP, 2 WRITE, 3 READ; called at a falling edge
    task automatic do_cmd(input int op, input logic [6:0] a, input bit rnw,
                          input logic [7:0] d, input string tag);
        logic [N-1:0] e_sel;
        int           e_kind;
        bit           e_nack;
        logic [7:0]   e_data;
        bit           mask;
        int           first;
        e_data = 8'hFF;
        e_nack = 1'b0;
        case (op)
            0: begin
                m_bc = (a == 7'h7E);
                if (m_bc && !m_daa) m_ccc = 1'b0;
                m_match = exp_hit(a, m_daa, t_hasda);
                e_sel = m_match;
                e_kind = rnw ? 1 : 0;
                e_nack = (m_match == '0);
            end
            1: begin
                e_sel = m_daa ? '1 : m_match;
                e_kind = 4;
                m_match = '0; m_bc = 0; m_ccc = 0; m_daa = 0; m_code = 8'h00;
            end
            2: begin
                if (m_bc && !m_ccc) begin
                    m_code = d; m_ccc = 1'b1;
                    if (d == 8'h07) m_daa = 1'b1;
                end
                e_sel = m_match;
                e_kind = 2;
                mask = m_ccc && !m_code[7];
                e_nack = (|(m_match & t_nack)) && !mask;
            end
            default: begin
                e_sel = m_match;
                e_kind = 3;
                mask = m_ccc && !m_code[7];
                first = -1;
                for (int i = N - 1; i >= 0; i--) if (m_match[i]) first = i;
                if (first >= 0) begin
                    e_data = 8'hA0 + 8'(first);
                    e_nack = t_nack[first] && !mask;
                end
            end
        endcase
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = a; cmd_rnw = rnw; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(evt_valid == 1'b1, tag, "event strobe", int'(evt_valid), 1);
        check(int'(evt_kind) == e_kind, tag, "event kind", int'(evt_kind), e_kind);
        check(sel == e_sel, tag, "target select", int'(sel), int'(e_sel));
        check(evt_cmd == m_ccc, tag, "in-command flag", int'(evt_cmd), int'(m_ccc));
        if (m_ccc) check(evt_code == m_code, tag, "command code", int'(evt_code), int'(m_code));
        check(busy == (|m_match), "R9", "busy", int'(busy), int'(|m_match));
        @(negedge clk);
        check(rsp_valid == 1'b1, tag, "response strobe", int'(rsp_valid), 1);
        check(rsp_nack == e_nack, tag, "nack", int'(rsp_nack), int'(e_nack));
        if (op == 3) check(rsp_rdata == e_data, tag, "read data", int'(rsp_rdata), int'(e_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] apool [6];
        logic [7:0] dpool [4];
        int         r;
        apool = '{7'h7E, 7'h10, 7'h11, 7'h12, 7'h13, 7'h33};
        dpool = '{8'h07, 8'h85, 8'h01, 8'h00};
        m_bc = 0; m_ccc = 0; m_daa = 0; m_code = 0; m_match = '0;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 0, "R1", "rsp_valid", int'(rsp_valid), 0);
        check(evt_valid == 0, "R1", "evt_valid", int'(evt_valid), 0);
        check(busy == 0, "R1", "busy", int'(busy), 0);
        check(sel == '0, "R1", "tgt_sel", int'(sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R6: broadcast command with bit 7 clear hides NACKs
        t_nack = 4'b1111;
        do_cmd(0, 7'h7E, 0, 0, "R3");
        check(sel == 4'b1111, "R3", "broadcast selects all", int'(sel), 15);
        do_cmd(2, 0, 0, 8'h01, "R3");
        do_cmd(2, 0, 0, 8'h55, "R6");
        check(rsp_nack == 0, "R6", "broadcast write ack", int'(rsp_nack), 0);
        do_cmd(1, 0, 0, 0, "R7");
        // R6 private write reports OR of NACKs; R4 direct match
        t_nack = 4'b0100;
        do_cmd(0, 7'h12, 0, 0, "R4");
        check(sel == 4'b0100, "R4", "direct select", int'(sel), 4);
        do_cmd(2, 0, 0, 8'h3C, "R6");
        check(rsp_nack == 1, "R6", "private write nack", int'(rsp_nack), 1);
        do_cmd(0, 7'h33, 0, 0, "R4");
        check(rsp_nack == 1, "R4", "no-match start nack", int'(rsp_nack), 1);
        do_cmd(1, 0, 0, 0, "R7");
        // R10: direct command persists over a non-broadcast restart
        t_nack = 4'b0010;
        do_cmd(0, 7'h7E, 0, 0, "R10");
        do_cmd(2, 0, 0, 8'h85, "R10");
        do_cmd(0, 7'h11, 0, 0, "R10");
        do_cmd(2, 0, 0, 8'h20, "R10");
        check(rsp_nack == 1 && evt_cmd == 1, "R10", "direct command nack", int'(rsp_nack), 1);
        do_cmd(0, 7'h7E, 0, 0, "R10");
        do_cmd(2, 0, 0, 8'h01, "R10");
        check(evt_code == 8'h01, "R10", "new code after broadcast restart", int'(evt_code), 1);
        do_cmd(1, 0, 0, 0, "R7");
        do_cmd(2, 0, 0, 8'h44, "R7");
        check(evt_cmd == 0, "R7", "no command after stop", int'(evt_cmd), 0);
        // R5, R8, R7: assignment round with two addressed targets
        t_hasda = 4'b0101;
        t_nack = 4'b1111;
        do_cmd(0, 7'h7E, 0, 0, "R5");
        do_cmd(2, 0, 0, 8'h07, "R5");
        do_cmd(0, 7'h7E, 1, 0, "R5");
        check(sel == 4'b1010, "R5", "round restart selects unaddressed", int'(sel), 10);
        do_cmd(3, 0, 0, 0, "R8");
        check(rsp_rdata == 8'hA1 && rsp_nack == 0, "R8", "first target read", int'(rsp_rdata), 'hA1);
        do_cmd(0, 7'h13, 0, 0, "R5");
        check(sel == 4'b0000 && rsp_nack == 1, "R5", "direct address in round", int'(sel), 0);
        do_cmd(3, 0, 0, 0, "R8");
        check(rsp_rdata == 8'hFF, "R8", "empty read", int'(rsp_rdata), 'hFF);
        do_cmd(1, 0, 0, 0, "R7");
        check(sel == 4'b1111, "R7", "round stop to all", int'(sel), 15);
        check(busy == 0, "R9", "idle after stop", int'(busy), 0);

        // constrained random sequences
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 8) == 0) t_hasda = 4'($urandom);
            t_nack = 4'($urandom);
            r = $urandom % 10;
            if (r < 3)       do_cmd(0, apool[$urandom % 6], 1'($urandom), 0, "R2");
            else if (r == 3) do_cmd(1, 0, 0, 0, "R2");
            else if (r < 8)  do_cmd(2, 0, 0, (($urandom % 2) == 0) ? dpool[$urandom % 4]
                                                                    : 8'($urandom), "R2");
            else             do_cmd(3, 0, 0, 0, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule